// File: doc/BRIEF.md
# RNS Programmable Power-of-Two Scaler

This block divides an integer held in residue form over the moduli {2^n-1, 2^n, 2^n+1} by 2^k and truncates the quotient. The shift amount k is chosen on every transfer. The quotient comes back as residues in the same three channels. There is no full binary conversion and no chain of divide-by-two stages. The low k bits of the 2^n residue are the remainder that is dropped. Subtracting that remainder leaves a multiple of 2^k. The odd channels then multiply by the inverse of 2^k: a rotation modulo 2^n-1, and a shifted, negated product modulo 2^n+1.

The 2^n channel needs the result bits k to k+n-1 of X. It gets them from a shared field: the low 2n bits of X, formed once from all three residues. Once that field and the remainder exist, each channel computes on its own. One register stage holds the result.

Top module: `rns_pow2_scaler`

## Requirements
- R1: One cycle after a transfer with valid_i high, res_m1_o equals floor(X/2^k) mod (2^N-1), where X in [0, (2^N-1)·2^N·(2^N+1)) is the integer whose residues were presented and k = shift_i.
- R2: One cycle after a transfer, res_m2_o equals floor(X/2^k) mod 2^N.
- R3: One cycle after a transfer, res_m3_o equals floor(X/2^k) mod (2^N+1).
- R4: With shift_i = 0 the three output residues equal the input residues.
- R5: With shift_i = N (the largest legal shift) all three residues are still exact, including for X = 0 and X at the top of the range.
- R6: valid_o is the value valid_i had one clock earlier.
- R7: While valid_i is low the three output residues keep their previous values, whatever is on the residue and shift inputs.
- R8: With rst_ni low, valid_o and all output residues are 0, asynchronously.
- R9: Output residues are canonical: res_m1_o < 2^N-1 and res_m3_o < 2^N+1. The all-ones pattern never stands for zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input transfer strobe |
| shift_i | input | $clog2(N+1) | Scaling exponent k, 0..N |
| res_m1_i | input | N | Input residue modulo 2^N-1 |
| res_m2_i | input | N | Input residue modulo 2^N |
| res_m3_i | input | N+1 | Input residue modulo 2^N+1 |
| valid_o | output | 1 | Output strobe, one cycle after valid_i |
| res_m1_o | output | N | Scaled residue modulo 2^N-1 |
| res_m2_o | output | N | Scaled residue modulo 2^N |
| res_m3_o | output | N+1 | Scaled residue modulo 2^N+1 |

## Verification
The bench builds the scaler with N = 5, the smallest supported width. The dynamic range is then 32736, so the sampled integers cover a large share of the range, including both ends. Each shift from 0 to 5 is visited in turn. At N = 5 the widest shift, k = N, consumes the whole 2^n residue as remainder and pulls the whole upper half of the shared field into the 2^n channel. Subtraction wrap-around in both odd channels then happens often.

// File: rtl/rns_field_form.sv
module rns_field_form #(
  parameter int unsigned N  = 8,
  parameter int unsigned KW = $clog2(N + 1)
) (
  input  logic [N-1:0]   x1_i,
  input  logic [N-1:0]   x2_i,
  input  logic [N:0]     x3_i,
  input  logic [KW-1:0]  k_i,
  output logic [N-1:0]   rem_o,
  output logic [2*N-1:0] low_o
);
  localparam logic [N+1:0] M3_W = (N+2)'(2**N + 1);

  // v * 2^j mod (2^N+1) by conditional doubling
  function automatic logic [N:0] m3_pow2(input logic [N:0] v_in, input int j);
    logic [N:0]   v;
    logic [N+1:0] d;
    v = v_in;
    for (int i = 0; i < int'(N); i++) begin
      if (i < j) begin
        d = {v, 1'b0};
        if (d >= M3_W) v = (N+1)'(d - M3_W);
        else           v = d[N:0];
      end
    end
    return v;
  endfunction

  logic [N:0]     x1_e, t, a;
  logic [2*N-1:0] a_w, x13;
  logic [N-1:0]   h;

  always_comb begin
    x1_e = {1'b0, x1_i};
    if (x3_i >= x1_e) t = x3_i - x1_e;
    else              t = (N+1)'({1'b0, x3_i} + M3_W - {2'b0, x1_i});
    // (2^N-1)^-1 mod (2^N+1) = 2^(N-1)
    a     = m3_pow2(t, int'(N) - 1);
    a_w   = {{(N-1){1'b0}}, a};
    x13   = (a_w << N) - a_w + {{N{1'b0}}, x1_i};
    h     = x13[N-1:0] - x2_i;
    low_o = x13 - {{N{1'b0}}, h};
    rem_o = x2_i & ~({N{1'b1}} << k_i);
  end
endmodule

// File: rtl/rns_chan_m1.sv
module rns_chan_m1 #(
  parameter int unsigned N  = 8,
  parameter int unsigned KW = $clog2(N + 1)
) (
  input  logic [N-1:0]  x_i,
  input  logic [N-1:0]  rem_i,
  input  logic [KW-1:0] k_i,
  output logic [N-1:0]  y_o
);
  localparam logic [N-1:0] M1 = {N{1'b1}};

  logic [N-1:0] rm, d, v;

  always_comb begin
    rm = (rem_i == M1) ? '0 : rem_i;
    d  = x_i - rm;
    if (x_i < rm) d = d - 1'b1;  // end-around borrow
    v = d;
    // times 2^-k == rotate right by k
    for (int i = 0; i < int'(N); i++) begin
      if (i < int'(k_i)) v = {v[0], v[N-1:1]};
    end
    y_o = v;
  end
endmodule

// File: rtl/rns_chan_m3.sv
module rns_chan_m3 #(
  parameter int unsigned N  = 8,
  parameter int unsigned KW = $clog2(N + 1)
) (
  input  logic [N:0]    x_i,
  input  logic [N-1:0]  rem_i,
  input  logic [KW-1:0] k_i,
  output logic [N:0]    y_o
);
  localparam logic [N+1:0] M3_W = (N+2)'(2**N + 1);
  localparam logic [N:0]   M3   = (N+1)'(2**N + 1);

  function automatic logic [N:0] m3_pow2(input logic [N:0] v_in, input int j);
    logic [N:0]   v;
    logic [N+1:0] d;
    v = v_in;
    for (int i = 0; i < int'(N); i++) begin
      if (i < j) begin
        d = {v, 1'b0};
        if (d >= M3_W) v = (N+1)'(d - M3_W);
        else           v = d[N:0];
      end
    end
    return v;
  endfunction

  logic [N:0] re, e, f;

  always_comb begin
    re = {1'b0, rem_i};
    if (x_i >= re) e = x_i - re;
    else           e = (N+1)'({1'b0, x_i} + M3_W - {1'b0, re});
    // 2^-k mod (2^N+1) = -2^(N-k)
    f   = m3_pow2(e, int'(N) - int'(k_i));
    y_o = (f == '0) ? '0 : M3 - f;
  end
endmodule

// File: rtl/rns_pow2_scaler.sv
module rns_pow2_scaler #(
  parameter int unsigned N  = 8,
  parameter int unsigned KW = $clog2(N + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [KW-1:0] shift_i,
  input  logic [N-1:0]  res_m1_i,
  input  logic [N-1:0]  res_m2_i,
  input  logic [N:0]    res_m3_i,
  output logic          valid_o,
  output logic [N-1:0]  res_m1_o,
  output logic [N-1:0]  res_m2_o,
  output logic [N:0]    res_m3_o
);
  logic [N-1:0]   rem;
  logic [2*N-1:0] low;
  logic [N-1:0]   y1, y2;
  logic [N:0]     y3;

  rns_field_form #(.N(N), .KW(KW)) u_field (
    .x1_i (res_m1_i), .x2_i (res_m2_i), .x3_i (res_m3_i),
    .k_i  (shift_i),  .rem_o(rem),      .low_o(low)
  );

  rns_chan_m1 #(.N(N), .KW(KW)) u_m1 (
    .x_i(res_m1_i), .rem_i(rem), .k_i(shift_i), .y_o(y1)
  );

  rns_chan_m3 #(.N(N), .KW(KW)) u_m3 (
    .x_i(res_m3_i), .rem_i(rem), .k_i(shift_i), .y_o(y3)
  );

  // 2^N channel: bits k..k+N-1 of the shared low field
  always_comb begin
    y2 = '0;
    for (int i = 0; i <= int'(N); i++) begin
      if (int'(shift_i) == i) y2 = low[i +: N];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      res_m1_o <= '0;
      res_m2_o <= '0;
      res_m3_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        res_m1_o <= y1;
        res_m2_o <= y2;
        res_m3_o <= y3;
      end
    end
  end

  AST_VALID_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i)) else $error("valid delay"); // R6

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(res_m1_o) && $stable(res_m2_o) && $stable(res_m3_o)))
    else $error("hold"); // R7

  AST_ZERO_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && shift_i == '0) |=> (res_m1_o == $past(res_m1_i) &&
     res_m2_o == $past(res_m2_i) && res_m3_o == $past(res_m3_i)))
    else $error("zero shift"); // R4

  AST_CANON_M1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> res_m1_o != {N{1'b1}}) else $error("m1 canon"); // R9

  AST_CANON_M3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> res_m3_o <= (N+1)'(2**N)) else $error("m3 canon"); // R9
endmodule

// File: tb/rns_pow2_scaler_test.sv
module rns_pow2_scaler_test;
  localparam int N        = 5;
  localparam int KW       = $clog2(N + 1);
  localparam int CLK_PER  = 10;
  localparam int M1       = 2**N - 1;
  localparam int M2       = 2**N;
  localparam int M3       = 2**N + 1;
  localparam int MRANGE   = M1 * M2 * M3;
  localparam int NVEC     = 12;
  // {X, k, floor(X/2^k)}
  localparam logic [47:0] VEC [NVEC] = '{
    {16'd0,     16'd0, 16'd0},
    {16'd32735, 16'd5, 16'd1022},
    {16'd32735, 16'd0, 16'd32735},
    {16'd31,    16'd1, 16'd15},
    {16'd32,    16'd5, 16'd1},
    {16'd1023,  16'd3, 16'd127},
    {16'd20000, 16'd4, 16'd1250},
    {16'd12345, 16'd2, 16'd3086},
    {16'd1,     16'd5, 16'd0},
    {16'd31,    16'd5, 16'd0},
    {16'd32734, 16'd1, 16'd16367},
    {16'd32704, 16'd5, 16'd1022}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid_i = 1'b0;
  logic [KW-1:0] shift_i = '0;
  logic [N-1:0]  r1_i = '0, r2_i = '0;
  logic [N:0]    r3_i = '0;
  logic          valid_o;
  logic [N-1:0]  r1_o, r2_o;
  logic [N:0]    r3_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PER/2) clk = ~clk;

  rns_pow2_scaler #(.N(N), .KW(KW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .shift_i(shift_i),
    .res_m1_i(r1_i), .res_m2_i(r2_i), .res_m3_i(r3_i),
    .valid_o(valid_o), .res_m1_o(r1_o), .res_m2_o(r2_o), .res_m3_o(r3_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at negedge, check at the following negedge
  task automatic apply(input int x, input int k, input int y);
    string tag;
    valid_i = 1'b1;
    shift_i = KW'(k);
    r1_i = N'(x % M1);
    r2_i = N'(x % M2);
    r3_i = (N+1)'(x % M3);
    @(negedge clk);
    tag = (k == 0) ? " R4" : ((k == N) ? " R5" : "");
    chk({"R6 valid_o", tag}, int'(valid_o), 1);
    chk({"R1 res_m1", tag}, int'(r1_o), y % M1);
    chk({"R2 res_m2", tag}, int'(r2_o), y % M2);
    chk({"R3 res_m3", tag}, int'(r3_o), y % M3);
    chk("R9 canonical", int'(r1_o < N'(M1) && r3_o < (N+1)'(M3)), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int x, k, y1h, y2h, y3h;
    repeat (3) @(negedge clk);
    chk("R8 reset valid_o", int'(valid_o), 0);
    chk("R8 reset res_m1", int'(r1_o), 0);
    chk("R8 reset res_m2", int'(r2_o), 0);
    chk("R8 reset res_m3", int'(r3_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++)
      apply(int'(VEC[i][47:32]), int'(VEC[i][31:16]), int'(VEC[i][15:0]));

    for (int i = 0; i < 3000; i++) begin
      x = int'($urandom % MRANGE);
      k = i % (N + 1);
      apply(x, k, x >> k);
    end

    // R7: idle cycle keeps the last result, R6: valid_o drops
    x = 29999; k = 3;
    apply(x, k, x >> k);
    y1h = (x >> k) % M1; y2h = (x >> k) % M2; y3h = (x >> k) % M3;
    valid_i = 1'b0;
    shift_i = '0;
    r1_i = N'(7); r2_i = N'(19); r3_i = (N+1)'(30);
    @(negedge clk);
    chk("R6 valid_o low", int'(valid_o), 0);
    chk("R7 hold res_m1", int'(r1_o), y1h);
    chk("R7 hold res_m2", int'(r2_o), y2h);
    chk("R7 hold res_m3", int'(r3_o), y3h);
    @(negedge clk);
    chk("R7 hold2 res_m2", int'(r2_o), y2h);

    // R8: asynchronous reset mid-run
    apply(MRANGE - 1, 2, (MRANGE - 1) >> 2);
    valid_i = 1'b0;
    #1 rst_n = 1'b0;
    #1;
    chk("R8 async valid_o", int'(valid_o), 0);
    chk("R8 async res_m1", int'(r1_o), 0);
    chk("R8 async res_m3", int'(r3_o), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule